// File: doc/BRIEF.md
# Dual-Wiper Potentiometer Register Write Slave

This block is a write-only I2C slave that holds the settings of a two-channel digital potentiometer. The bus lines come in through synchronizers clocked by a fast system clock, and the block detects START, STOP and repeated START in that clock domain. It acknowledges an address byte that matches its fixed pattern and strap inputs. It then treats every later byte as a self-describing command: the top two bits select a register and the low six bits carry the new value.

A STOP closes the transaction. If the configuration register has nonvolatile mode selected at that moment, the block raises a one-cycle store request so that a neighbouring storage controller can save the current values. The chip-enable input gates the whole interface. The system clock must run at least eight times faster than SCL.

Top module: `wp_slave_top`

## Requirements
- R1: After reset, both wiper outputs and the configuration output are 0, SDA is released (`sda_pull` = 0) and no store request is raised.
- R2: An address byte whose first seven bits are 0101 followed by `strap[2]`, `strap[1]`, `strap[0]`, and whose eighth bit (R/W) is 0, is acknowledged: `sda_pull` is 1 while SCL is high on the ninth clock. The pull-down only ever begins while SCL is low.
- R3: An address byte that does not match, or that has R/W = 1, gets no acknowledge. All bytes after it are ignored, with no acknowledge and no register change, until the next START.
- R4: A data byte with bits [7:6] = 00 loads bits [5:0] into wiper 0, 01 loads wiper 1, and 10 loads the configuration register. Each such byte is acknowledged. Several bytes may follow one address byte in any order, and each byte changes only its own register.
- R5: A data byte with bits [7:6] = 11 is acknowledged and changes no register.
- R6: A STOP that ends an addressed transaction while configuration bit 0 is 1 produces a store request exactly one system clock long.
- R7: While configuration bit 0 is 0, a STOP produces no store request. A STOP on a transaction that was never addressed produces none in either mode.
- R8: A repeated START returns the block to the address phase. A matching address is acknowledged again, and the data bytes that follow are applied.
- R9: A STOP or repeated START in the middle of a byte discards the partial byte, leaving every register unchanged.
- R10: While `chip_en` is 0, SDA is released within one system clock and the block returns to idle. Bytes that finish after chip enable returns are not acknowledged until the next START.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock, at least 8x SCL |
| rst | input | 1 | Synchronous active-high reset |
| scl_i | input | 1 | SCL line level |
| sda_i | input | 1 | SDA line level |
| chip_en | input | 1 | Interface enable, active high |
| strap | input | 3 | Address strap inputs {A2,A1,A0} |
| sda_pull | output | 1 | 1 = pull SDA low (acknowledge) |
| wiper0 | output | 6 | Wiper 0 setting |
| wiper1 | output | 6 | Wiper 1 setting |
| cfg | output | 6 | Configuration register, bit 0 = nonvolatile mode |
| store_req | output | 1 | One-cycle request to save current values |

## Verification
A wrong bit count or a wrong decode state shows up within a single byte. The acknowledge is then either missing or present on the ninth clock, and that is visible at `sda_pull` before the next byte begins. A wrong register selection shows on the wiper and configuration outputs within a few system clocks of the acknowledge. A wrong record of whether the transaction was addressed, or of the mode, shows only when the STOP arrives, as a missing or extra `store_req` pulse. For that reason every scenario ends with a STOP and then a check of the pulse count.

// File: rtl/wp_pkg.sv
package wp_pkg;
    localparam int VAL_W     = 6;
    localparam int BYTE_BITS = 8;
    localparam int STRAP_W   = 3;
    localparam logic [3:0] ADDR_FIXED = 4'b0101;

    typedef enum logic [2:0] {
        ST_IDLE, ST_ADDR, ST_ADDR_ACK, ST_DATA, ST_DATA_ACK
    } bus_state_e;

    typedef enum logic [1:0] {
        SEL_W0 = 2'b00, SEL_W1 = 2'b01, SEL_CFG = 2'b10, SEL_NONE = 2'b11
    } reg_sel_e;

    typedef struct packed {
        reg_sel_e          sel;
        logic [VAL_W-1:0]  val;
    } cmd_t;

    typedef struct packed {
        logic start;
        logic stop;
        logic scl_rise;
        logic scl_fall;
        logic scl_lvl;
        logic sda_lvl;
    } bus_ev_t;

    function automatic logic addr_hit(input logic [7:0] b, input logic [STRAP_W-1:0] s);
        return (b[7:1] == {ADDR_FIXED, s}) && (b[0] == 1'b0);
    endfunction
endpackage

// File: rtl/wp_bus_sync.sv
module wp_bus_sync
    import wp_pkg::*;
#(
    parameter int SYNC_STAGES = 2
) (
    input  logic    clk,
    input  logic    rst,
    input  logic    scl_i,
    input  logic    sda_i,
    output bus_ev_t ev
);
    logic [SYNC_STAGES-1:0] scl_pipe, sda_pipe;
    logic scl_q, sda_q;
    logic scl_s, sda_s;

    assign scl_s = scl_pipe[SYNC_STAGES-1];
    assign sda_s = sda_pipe[SYNC_STAGES-1];

    always_ff @(posedge clk) begin
        if (rst) begin
            scl_pipe <= '1;
            sda_pipe <= '1;
            scl_q    <= 1'b1;
            sda_q    <= 1'b1;
        end else begin
            scl_pipe <= {scl_pipe[SYNC_STAGES-2:0], scl_i};
            sda_pipe <= {sda_pipe[SYNC_STAGES-2:0], sda_i};
            scl_q    <= scl_s;
            sda_q    <= sda_s;
        end
    end

    always_comb begin
        ev.start    = scl_s & scl_q & sda_q & ~sda_s;
        ev.stop     = scl_s & scl_q & ~sda_q & sda_s;
        ev.scl_rise = scl_s & ~scl_q;
        ev.scl_fall = ~scl_s & scl_q;
        ev.scl_lvl  = scl_s;
        ev.sda_lvl  = sda_s;
    end
endmodule

// File: rtl/wp_byte_rx.sv
module wp_byte_rx
    import wp_pkg::*;
(
    input  logic               clk,
    input  logic               rst,
    input  bus_ev_t            ev,
    input  logic               chip_en,
    input  logic [STRAP_W-1:0] strap,
    output logic               sda_pull,
    output logic               byte_stb,
    output cmd_t               cmd,
    output logic               stop_stb
);
    localparam int CNT_W = $clog2(BYTE_BITS + 1);

    bus_state_e       state;
    logic [CNT_W-1:0] bit_cnt;
    logic [7:0]       shreg;
    logic             addressed;

    assign cmd       = cmd_t'(shreg);
    assign addressed = (state == ST_ADDR_ACK) || (state == ST_DATA) || (state == ST_DATA_ACK);

    always_ff @(posedge clk) begin
        if (rst) begin
            state    <= ST_IDLE;
            bit_cnt  <= '0;
            shreg    <= '0;
            sda_pull <= 1'b0;
            byte_stb <= 1'b0;
            stop_stb <= 1'b0;
        end else begin
            byte_stb <= 1'b0;
            stop_stb <= 1'b0;
            if (!chip_en) begin
                state    <= ST_IDLE;
                bit_cnt  <= '0;
                sda_pull <= 1'b0;
            end else if (ev.start) begin
                state    <= ST_ADDR;
                bit_cnt  <= '0;
                sda_pull <= 1'b0;
            end else if (ev.stop) begin
                stop_stb <= addressed;
                state    <= ST_IDLE;
                bit_cnt  <= '0;
                sda_pull <= 1'b0;
            end else begin
                case (state)
                    ST_ADDR, ST_DATA: begin
                        if (ev.scl_rise && bit_cnt < CNT_W'(BYTE_BITS)) begin
                            shreg   <= {shreg[6:0], ev.sda_lvl};
                            bit_cnt <= bit_cnt + 1'b1;
                        end else if (ev.scl_fall && bit_cnt == CNT_W'(BYTE_BITS)) begin
                            bit_cnt <= '0;
                            if (state == ST_ADDR) begin
                                if (addr_hit(shreg, strap)) begin
                                    sda_pull <= 1'b1;
                                    state    <= ST_ADDR_ACK;
                                end else begin
                                    state    <= ST_IDLE;
                                end
                            end else begin
                                sda_pull <= 1'b1;
                                byte_stb <= 1'b1;
                                state    <= ST_DATA_ACK;
                            end
                        end
                    end
                    ST_ADDR_ACK, ST_DATA_ACK: begin
                        if (ev.scl_fall) begin
                            sda_pull <= 1'b0;
                            bit_cnt  <= '0;
                            state    <= ST_DATA;
                        end
                    end
                    default: state <= ST_IDLE;
                endcase
            end
        end
    end

    AST_ACK_STARTS_SCL_LOW: assert property (@(posedge clk) disable iff (rst)
        $rose(sda_pull) |-> !ev.scl_lvl);  // R2
    AST_RELEASE_ON_DISABLE: assert property (@(posedge clk) disable iff (rst)
        !chip_en |=> !sda_pull);  // R10
    AST_STROBE_NEEDS_ACK: assert property (@(posedge clk) disable iff (rst)
        byte_stb |-> sda_pull);  // R4
endmodule

// File: rtl/wp_reg_bank.sv
module wp_reg_bank
    import wp_pkg::*;
(
    input  logic             clk,
    input  logic             rst,
    input  logic             byte_stb,
    input  cmd_t             cmd,
    input  logic             stop_stb,
    output logic [VAL_W-1:0] wiper0,
    output logic [VAL_W-1:0] wiper1,
    output logic [VAL_W-1:0] cfg,
    output logic             store_req
);
    always_ff @(posedge clk) begin
        if (rst) begin
            wiper0    <= '0;
            wiper1    <= '0;
            cfg       <= '0;
            store_req <= 1'b0;
        end else begin
            store_req <= stop_stb & cfg[0];
            if (byte_stb) begin
                case (cmd.sel)
                    SEL_W0:  wiper0 <= cmd.val;
                    SEL_W1:  wiper1 <= cmd.val;
                    SEL_CFG: cfg    <= cmd.val;
                    default: ;
                endcase
            end
        end
    end

    AST_STORE_ONE_CYCLE: assert property (@(posedge clk) disable iff (rst)
        store_req |=> !store_req);  // R6
    AST_STORE_AFTER_STOP: assert property (@(posedge clk) disable iff (rst)
        store_req |-> $past(stop_stb));  // R6
    AST_STORE_NV_ONLY: assert property (@(posedge clk) disable iff (rst)
        store_req |-> cfg[0]);  // R7
    AST_REGS_HOLD: assert property (@(posedge clk) disable iff (rst)
        !byte_stb |=> ($stable(wiper0) && $stable(wiper1) && $stable(cfg)));  // R9
endmodule

// File: rtl/wp_slave_top.sv
module wp_slave_top
    import wp_pkg::*;
#(
    parameter int SYNC_STAGES = 2
) (
    input  logic               clk,
    input  logic               rst,
    input  logic               scl_i,
    input  logic               sda_i,
    input  logic               chip_en,
    input  logic [STRAP_W-1:0] strap,
    output logic               sda_pull,
    output logic [VAL_W-1:0]   wiper0,
    output logic [VAL_W-1:0]   wiper1,
    output logic [VAL_W-1:0]   cfg,
    output logic               store_req
);
    bus_ev_t ev;
    cmd_t    cmd;
    logic    byte_stb;
    logic    stop_stb;

    wp_bus_sync #(.SYNC_STAGES(SYNC_STAGES)) u_sync (
        .clk(clk), .rst(rst), .scl_i(scl_i), .sda_i(sda_i), .ev(ev)
    );

    wp_byte_rx u_rx (
        .clk(clk), .rst(rst), .ev(ev), .chip_en(chip_en), .strap(strap),
        .sda_pull(sda_pull), .byte_stb(byte_stb), .cmd(cmd), .stop_stb(stop_stb)
    );

    wp_reg_bank u_regs (
        .clk(clk), .rst(rst), .byte_stb(byte_stb), .cmd(cmd), .stop_stb(stop_stb),
        .wiper0(wiper0), .wiper1(wiper1), .cfg(cfg), .store_req(store_req)
    );
endmodule

// File: tb/wp_slave_top_test.sv
module wp_slave_top_test;
    localparam int Q = 10;
    localparam logic [2:0] STRAP = 3'b101;
    localparam logic [7:0] ADDR_W = {4'b0101, STRAP, 1'b0};

    logic clk = 1'b0;
    logic rst = 1'b1;
    logic scl_m = 1'b1;
    logic sda_m = 1'b1;
    logic chip_en = 1'b1;
    logic sda_pull, store_req;
    logic [5:0] wiper0, wiper1, cfg;
    logic sda_line;
    int checks = 0;
    int errors = 0;
    int stores = 0;
    bit done = 0;

    assign sda_line = sda_m & ~sda_pull;

    always #10 clk = ~clk;

    wp_slave_top uut (
        .clk(clk), .rst(rst), .scl_i(scl_m), .sda_i(sda_line), .chip_en(chip_en),
        .strap(STRAP), .sda_pull(sda_pull), .wiper0(wiper0), .wiper1(wiper1),
        .cfg(cfg), .store_req(store_req)
    );

    always @(posedge clk) if (!rst && store_req) stores++;

    task automatic chk(input string req, input int act, input int exp);
        checks++;
        if (act != exp) begin
            errors++;
            $display("FAIL %s: actual %0d expected %0d", req, act, exp);
        end
    endtask

    task automatic w(input int n);
        repeat (n) @(negedge clk);
    endtask

    task automatic bus_start();
        sda_m = 1'b0; w(Q); scl_m = 1'b0; w(Q);
    endtask

    task automatic bus_rstart();
        w(Q); sda_m = 1'b1; w(Q); scl_m = 1'b1; w(Q); sda_m = 1'b0; w(Q); scl_m = 1'b0;
    endtask

    task automatic bus_stop();
        w(Q); sda_m = 1'b0; w(Q); scl_m = 1'b1; w(Q); sda_m = 1'b1; w(4 * Q);
    endtask

    task automatic send_bit(input logic b);
        w(Q); sda_m = b; w(Q); scl_m = 1'b1; w(2 * Q); scl_m = 1'b0;
    endtask

    task automatic send_byte(input logic [7:0] b, output logic ackd);
        for (int i = 7; i >= 0; i--) send_bit(b[i]);
        w(Q); sda_m = 1'b1; w(Q); scl_m = 1'b1; w(Q);
        ackd = sda_pull;
        w(Q); scl_m = 1'b0;
    endtask

    task automatic t_reset();
        chk("R1 wiper0", wiper0, 0);
        chk("R1 wiper1", wiper1, 0);
        chk("R1 cfg", cfg, 0);
        chk("R1 sda_pull", sda_pull, 0);
        chk("R1 store", stores, 0);
    endtask

    task automatic t_volatile_write();
        logic a;
        int s0 = stores;
        bus_start();
        send_byte(ADDR_W, a);  chk("R2 addr ack", a, 1);
        send_byte(8'b00_101010, a); chk("R4 w0 ack", a, 1);
        send_byte(8'b01_010101, a); chk("R4 w1 ack", a, 1);
        bus_stop();
        chk("R4 wiper0", wiper0, 6'h2A);
        chk("R4 wiper1", wiper1, 6'h15);
        chk("R7 no store volatile", stores - s0, 0);
    endtask

    task automatic t_any_order();
        logic a;
        bus_start();
        send_byte(ADDR_W, a);
        send_byte(8'b01_000011, a);
        send_byte(8'b00_111111, a);
        send_byte(8'b01_000100, a);
        bus_stop();
        chk("R4 order wiper0", wiper0, 63);
        chk("R4 order wiper1", wiper1, 4);
    endtask

    task automatic t_code11();
        logic a;
        bus_start();
        send_byte(ADDR_W, a);
        send_byte(8'b11_101101, a); chk("R5 code11 ack", a, 1);
        bus_stop();
        chk("R5 wiper0", wiper0, 63);
        chk("R5 wiper1", wiper1, 4);
        chk("R5 cfg", cfg, 0);
    endtask

    task automatic t_nv_store();
        logic a;
        int s0 = stores;
        bus_start();
        send_byte(ADDR_W, a);
        send_byte(8'b10_000001, a); chk("R4 cfg ack", a, 1);
        send_byte(8'b00_000111, a);
        chk("R6 no store before stop", stores - s0, 0);
        bus_stop();
        chk("R4 cfg", cfg, 1);
        chk("R4 wiper0", wiper0, 7);
        chk("R6 one store pulse", stores - s0, 1);
    endtask

    task automatic t_mismatch();
        logic a;
        int s0 = stores;
        bus_start();
        send_byte({4'b0101, 3'b100, 1'b0}, a); chk("R3 bad strap no ack", a, 0);
        send_byte(8'b00_000000, a);            chk("R3 follow byte no ack", a, 0);
        bus_stop();
        bus_start();
        send_byte(ADDR_W | 8'h01, a);          chk("R3 read no ack", a, 0);
        send_byte(8'b01_000000, a);            chk("R3 follow byte no ack rd", a, 0);
        bus_stop();
        chk("R3 wiper0 kept", wiper0, 7);
        chk("R3 wiper1 kept", wiper1, 4);
        chk("R7 no store unaddressed", stores - s0, 0);
    endtask

    task automatic t_rstart();
        logic a;
        int s0 = stores;
        bus_start();
        send_byte(ADDR_W, a);
        send_byte(8'b00_001001, a);
        bus_rstart();
        send_byte(ADDR_W, a);        chk("R8 addr ack after rstart", a, 1);
        send_byte(8'b01_001100, a);  chk("R8 data ack after rstart", a, 1);
        bus_stop();
        chk("R8 wiper0", wiper0, 9);
        chk("R8 wiper1", wiper1, 12);
        chk("R6 store after rstart txn", stores - s0, 1);
    endtask

    task automatic t_partial();
        logic a;
        bus_start();
        send_byte(ADDR_W, a);
        send_bit(1'b0); send_bit(1'b0); send_bit(1'b1); send_bit(1'b1);
        bus_stop();
        chk("R9 stop drops partial", wiper0, 9);
        bus_start();
        send_byte(ADDR_W, a);
        send_bit(1'b0); send_bit(1'b0); send_bit(1'b0); send_bit(1'b1); send_bit(1'b1);
        bus_rstart();
        send_byte(ADDR_W, a);
        send_byte(8'b01_000001, a);
        bus_stop();
        chk("R9 rstart drops partial", wiper0, 9);
        chk("R9 later byte applied", wiper1, 1);
    endtask

    task automatic t_chip_enable();
        logic a;
        int s0;
        bus_start();
        send_byte(ADDR_W, a);
        send_bit(1'b0); send_bit(1'b0);
        chip_en = 1'b0; w(2);
        chk("R10 released when disabled", sda_pull, 0);
        send_bit(1'b1); send_bit(1'b1);
        chip_en = 1'b1;
        send_bit(1'b0); send_bit(1'b0); send_bit(1'b0); send_bit(1'b0);
        w(Q); sda_m = 1'b1; w(Q); scl_m = 1'b1; w(Q);
        chk("R10 no ack after re-enable", sda_pull, 0);
        w(Q); scl_m = 1'b0;
        s0 = stores;
        bus_stop();
        chk("R10 wiper0 unchanged", wiper0, 9);
        chk("R10 no store idle", stores - s0, 0);
        bus_start();
        send_byte(ADDR_W, a);
        send_byte(8'b10_000000, a);
        s0 = stores;
        bus_stop();
        chk("R7 cfg cleared", cfg, 0);
        chk("R7 no store after cfg cleared", stores - s0, 0);
    endtask

    initial begin
        w(5);
        rst = 1'b0;
        w(5);
        t_reset();
        t_volatile_write();
        t_any_order();
        t_code11();
        t_nv_store();
        t_mismatch();
        t_rstart();
        t_partial();
        t_chip_enable();
        if (!done) begin
            done = 1;
            $display("Simulation finished: %0d checks, %0d errors", checks, errors);
            $finish;
        end
    end

    initial begin
        repeat (150000) @(posedge clk);
        if (!done) begin
            done = 1;
            checks++;
            errors++;
            $display("FAIL watchdog: actual timeout expected completion");
            $display("Simulation finished: %0d checks, %0d errors", checks, errors);
            $finish;
        end
    end
endmodule